// File: doc/BRIEF.md
# USB Host Port Status and Wake Register

This block is the per-port status and control word of a USB 2.0 host controller. It lives in the always-on power domain, so only a host controller reset (`rst`), or the first power-up that asserts that same reset, returns it to its defaults. Software writes it over a simple register bus and reads it back as one 32-bit word. The word holds three wake enables, a 4-bit port test-mode field, two reserved read/write bits and a port-owner bit. It also shows the live connect and overcurrent status of the port.

The connect and overcurrent inputs are asynchronous to the register clock. They pass through a synchronizer of `SYNC_STAGES` flops. Edges are then detected on the synchronized values. A connect edge (0 to 1), a disconnect edge (1 to 0) or an overcurrent rising edge raises a power-management event, but only when that event's wake enable is set. The three qualified events are ORed and registered into a single one-cycle pulse on `pme_pulse`. The port-owner bit hands the port to a companion controller when it is 1. The block clears it by itself on every rising edge of the controller's configured flag.

Top module: `usb_port_wake_reg`

## Requirements
- R1: After reset, `rd_data` reads 32'h0000_2000: port owner (bit 13) is 1, and the wake enables (bits 22:20), the test field (bits 19:16), the reserved bits (15:14), connect status (bit 0) and overcurrent status (bit 4) are 0. `pme_pulse` and `test_active` are 0.
- R2: Bits 31:23 and bits 12:5, 3:1 always read 0, whatever is written.
- R3: A write with `wr_en` high loads `wr_data[22:13]` into bits 22:13 at the clock edge. This covers the reserved bits 15:14 and the reserved test codes 4'b0110 to 4'b1111, which are stored as written. The new value reads back in the next cycle.
- R4: Bit 0 shows `conn_in` and bit 4 shows `ovc_in`, each `SYNC_STAGES` clock edges after the input changes. With the default of 2 stages, an input changed before edge k shows at edge k+1.
- R5: When wake-on-connect (bit 20) is 1 and synchronized connect status goes from 0 to 1, `pme_pulse` is high for exactly one cycle. It starts one edge after bit 0 first reads 1.
- R6: When wake-on-disconnect (bit 21) is 1 and synchronized connect status goes from 1 to 0, `pme_pulse` is high for exactly one cycle.
- R7: When wake-on-overcurrent (bit 22) is 1 and synchronized overcurrent status rises, `pme_pulse` is high for exactly one cycle, even if overcurrent stays active.
- R8: An edge whose wake enable is 0 produces no pulse.
- R9: A 0-to-1 transition of `cfg_flag` clears port owner at the next edge. This clear wins over a write of 1 in the same cycle, while the rest of that write still takes effect. While `cfg_flag` stays high, software may write port owner to 1 and the value holds.
- R10: `test_mode` equals bits 19:16, and `test_active` is 1 exactly when that field is non-zero. The code 4'b0000 means normal operation, and 4'b0001 to 4'b0101 select J state, K state, SE0/NAK, test packet and force-enable.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Register clock |
| rst | input | 1 | Synchronous active-high host controller reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 32 | Register write data |
| rd_data | output | 32 | Register read data |
| conn_in | input | 1 | Asynchronous current connect status |
| ovc_in | input | 1 | Asynchronous overcurrent active |
| cfg_flag | input | 1 | Controller configured flag |
| pme_pulse | output | 1 | One-cycle power-management event request |
| port_owner | output | 1 | 1 = companion controller owns the port |
| test_mode | output | 4 | Current test-control code |
| test_active | output | 1 | Test-control field is non-zero |

## Verification
The hardest case to reach is a rising edge of the configured flag in the same clock as a software write that sets port owner. The stimulus drives both on one falling edge, so that they land together on the next rising edge. It then checks that port owner is 0 while the other written fields are kept. Wake timing is also hard to see from the ports, because it sits behind the synchronizer. The bench counts pulses at every falling edge over a window after each input change, so a doubled, missing or stretched pulse is caught. One connect event is also checked at its exact cycle.

// File: rtl/uwr_pkg.sv
package uwr_pkg;

    // Bit positions the read word is decoded by
    localparam int BIT_CONN  = 0;
    localparam int BIT_OVC   = 4;
    localparam int CTRL_LSB  = 13;
    localparam int CTRL_W    = 10;
    localparam int CTRL_MSB  = CTRL_LSB + CTRL_W - 1;
    localparam int WORD_W    = 32;

    typedef enum logic [3:0] {
        TM_NORMAL  = 4'd0,
        TM_J       = 4'd1,
        TM_K       = 4'd2,
        TM_SE0_NAK = 4'd3,
        TM_PACKET  = 4'd4,
        TM_FORCE   = 4'd5
    } tmode_e;

    // Packed so that it lines up with word bits 22:13
    typedef struct packed {
        logic       wk_ovc;
        logic       wk_disc;
        logic       wk_conn;
        logic [3:0] tmode;
        logic [1:0] rsv;
        logic       owner;
    } ctrl_t;

    localparam ctrl_t CTRL_RESET = '{wk_ovc: 1'b0, wk_disc: 1'b0, wk_conn: 1'b0,
                                     tmode: TM_NORMAL, rsv: 2'b00, owner: 1'b1};

    typedef struct packed {
        logic conn;
        logic ovc;
    } stat_t;

    function automatic logic [WORD_W-1:0] pack_word(input ctrl_t c, input stat_t s);
        logic [WORD_W-1:0] w;
        w = '0;
        w[CTRL_MSB:CTRL_LSB] = c;
        w[BIT_CONN] = s.conn;
        w[BIT_OVC]  = s.ovc;
        return w;
    endfunction

endpackage

// File: rtl/uwr_sync.sv
module uwr_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d_async,
    output logic [WIDTH-1:0] q_sync
);
    genvar b;
    generate
        for (b = 0; b < WIDTH; b++) begin : g_bit
            logic [STAGES-1:0] chain;
            always_ff @(posedge clk) begin
                if (rst) chain <= '0;
                else if (STAGES == 1) chain <= d_async[b];
                else chain <= {chain[STAGES-2:0], d_async[b]};
            end
            assign q_sync[b] = chain[STAGES-1];
        end
    endgenerate
endmodule

// File: rtl/uwr_evt.sv
module uwr_evt
    import uwr_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  stat_t stat,
    input  ctrl_t ctrl,
    output logic  pme_pulse
);
    stat_t prev;
    logic  ev_conn, ev_disc, ev_ovc;

    always_comb begin
        ev_conn = ctrl.wk_conn &  stat.conn & ~prev.conn;
        ev_disc = ctrl.wk_disc & ~stat.conn &  prev.conn;
        ev_ovc  = ctrl.wk_ovc  &  stat.ovc  & ~prev.ovc;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            prev      <= '0;
            pme_pulse <= 1'b0;
        end else begin
            prev      <= stat;
            pme_pulse <= ev_conn | ev_disc | ev_ovc;
        end
    end
endmodule

// File: rtl/uwr_ctrl.sv
module uwr_ctrl
    import uwr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              cfg_flag,
    output ctrl_t             ctrl
);
    logic  cfg_prev;
    logic  cfg_rise;
    ctrl_t nxt;

    assign cfg_rise = cfg_flag & ~cfg_prev;

    always_comb begin
        nxt = ctrl;
        if (wr_en) nxt = ctrl_t'(wr_data[CTRL_MSB:CTRL_LSB]);
        if (cfg_rise) nxt.owner = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl     <= CTRL_RESET;
            cfg_prev <= 1'b0;
        end else begin
            ctrl     <= nxt;
            cfg_prev <= cfg_flag;
        end
    end
endmodule

// File: rtl/usb_port_wake_reg.sv
module usb_port_wake_reg
    import uwr_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_en,
    input  logic [31:0] wr_data,
    output logic [31:0] rd_data,
    input  logic        conn_in,
    input  logic        ovc_in,
    input  logic        cfg_flag,
    output logic        pme_pulse,
    output logic        port_owner,
    output logic [3:0]  test_mode,
    output logic        test_active
);
    ctrl_t      ctrl;
    stat_t      stat;
    logic [1:0] st_sync;

    uwr_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .d_async ({conn_in, ovc_in}),
        .q_sync  (st_sync)
    );

    assign stat = stat_t'(st_sync);

    uwr_ctrl u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .cfg_flag (cfg_flag),
        .ctrl     (ctrl)
    );

    uwr_evt u_evt (
        .clk       (clk),
        .rst       (rst),
        .stat      (stat),
        .ctrl      (ctrl),
        .pme_pulse (pme_pulse)
    );

    assign rd_data     = pack_word(ctrl, stat);
    assign port_owner  = ctrl.owner;
    assign test_mode   = ctrl.tmode;
    assign test_active = (ctrl.tmode != TM_NORMAL);
endmodule

// File: rtl/uwr_chk.sv
module uwr_chk (
    input logic        clk,
    input logic        rst,
    input logic        wr_en,
    input logic [31:0] wr_data,
    input logic [31:0] rd_data,
    input logic        cfg_flag,
    input logic        pme_pulse,
    input logic        port_owner,
    input logic [3:0]  test_mode,
    input logic        test_active
);
    // R1
    reset_default_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (rd_data[22:13] == 10'b0000000001 && !pme_pulse));

    // R2
    reserved_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_data[31:23] == 9'd0 && rd_data[12:5] == 8'd0 && rd_data[3:1] == 3'd0));

    // R3
    write_store_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !(cfg_flag && !$past(cfg_flag))) |=> rd_data[22:13] == $past(wr_data[22:13]));

    // R8
    pme_enabled_chk: assert property (@(posedge clk) disable iff (rst)
        pme_pulse |-> $past(rd_data[22:20]) != 3'b000);

    // R9
    owner_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg_flag && !$past(cfg_flag) && !$past(rst)) |=> !port_owner);

    // R10
    test_flag_chk: assert property (@(posedge clk) disable iff (rst)
        (test_active == (test_mode != 4'd0)) && (test_mode == rd_data[19:16]));
endmodule

bind usb_port_wake_reg uwr_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .wr_en       (wr_en),
    .wr_data     (wr_data),
    .rd_data     (rd_data),
    .cfg_flag    (cfg_flag),
    .pme_pulse   (pme_pulse),
    .port_owner  (port_owner),
    .test_mode   (test_mode),
    .test_active (test_active)
);

// File: tb/usb_port_wake_reg_tb.sv
module usb_port_wake_reg_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        conn_in = 1'b0;
    logic        ovc_in = 1'b0;
    logic        cfg_flag = 1'b0;
    logic        pme_pulse;
    logic        port_owner;
    logic [3:0]  test_mode;
    logic        test_active;

    int checks = 0;
    int failures = 0;
    int pulses = 0;

    always #4 clk = ~clk;

    usb_port_wake_reg u_dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
        .conn_in(conn_in), .ovc_in(ovc_in), .cfg_flag(cfg_flag), .pme_pulse(pme_pulse),
        .port_owner(port_owner), .test_mode(test_mode), .test_active(test_active)
    );

    always @(negedge clk) if (pme_pulse) pulses++;

    // {write data, expected read word with status inputs low}
    localparam int NVEC = 8;
    localparam logic [63:0] VEC [NVEC] = '{
        {32'hFFFF_FFFF, 32'h007F_E000},
        {32'h0000_0000, 32'h0000_0000},
        {32'h0050_0000, 32'h0050_0000},
        {32'h000F_0000, 32'h000F_0000},
        {32'h0000_C000, 32'h0000_C000},
        {32'h0000_2000, 32'h0000_2000},
        {32'hFF80_1FFF, 32'h0000_0000},
        {32'h0036_2000, 32'h0036_2000}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    task automatic wr(input logic [31:0] d);
        wr_data = d;
        wr_en = 1'b1;
        tick(1);
        wr_en = 1'b0;
    endtask

    task automatic done;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        #1_000_000;
        failures++;
        $display("FAIL watchdog actual=timeout expected=completion");
        done();
    end

    initial begin
        tick(3);
        rst = 1'b0;
        // R1 reset state
        chk("R1 word", rd_data, 32'h0000_2000);
        chk("R1 pme", {31'd0, pme_pulse}, 32'd0);
        chk("R1 test_active", {31'd0, test_active}, 32'd0);

        // R2 R3 R10 table walk
        for (int i = 0; i < NVEC; i++) begin
            wr(VEC[i][63:32]);
            chk("R3 readback", rd_data, VEC[i][31:0]);
            chk("R10 test_mode", {28'd0, test_mode}, {28'd0, VEC[i][19:16]});
            chk("R10 test_active", {31'd0, test_active}, {31'd0, VEC[i][19:16] != 4'd0});
        end

        // R4 R5 exact timing of connect wake
        wr(32'h0010_0000);
        pulses = 0;
        conn_in = 1'b1;
        tick(1);
        chk("R4 conn not yet", {31'd0, rd_data[0]}, 32'd0);
        tick(1);
        chk("R4 conn shown", {31'd0, rd_data[0]}, 32'd1);
        chk("R5 no early pulse", {31'd0, pme_pulse}, 32'd0);
        tick(1);
        chk("R5 pulse cycle", {31'd0, pme_pulse}, 32'd1);
        tick(1);
        chk("R5 pulse ends", {31'd0, pme_pulse}, 32'd0);
        tick(4);
        chk("R5 one pulse", pulses, 1);

        // R8 disconnect with only connect enabled
        pulses = 0;
        conn_in = 1'b0;
        tick(6);
        chk("R8 disc disabled", pulses, 0);
        chk("R4 conn cleared", {31'd0, rd_data[0]}, 32'd0);

        // R6 disconnect wake
        wr(32'h0020_0000);
        conn_in = 1'b1;
        tick(6);
        pulses = 0;
        conn_in = 1'b0;
        tick(6);
        chk("R6 disc pulse", pulses, 1);

        // R7 overcurrent wake, held active
        wr(32'h0040_0000);
        pulses = 0;
        ovc_in = 1'b1;
        tick(8);
        chk("R7 ovc one pulse", pulses, 1);
        chk("R4 ovc shown", {31'd0, rd_data[4]}, 32'd1);
        ovc_in = 1'b0;
        tick(4);

        // R8 all disabled
        wr(32'h0000_0000);
        pulses = 0;
        conn_in = 1'b1; ovc_in = 1'b1;
        tick(6);
        conn_in = 1'b0; ovc_in = 1'b0;
        tick(6);
        chk("R8 all disabled", pulses, 0);

        // R9 plain configured-flag rise
        wr(32'h0000_2000);
        cfg_flag = 1'b1;
        tick(1);
        chk("R9 owner cleared", {31'd0, port_owner}, 32'd0);
        wr(32'h0000_2000);
        tick(2);
        chk("R9 owner held while flag high", {31'd0, port_owner}, 32'd1);
        cfg_flag = 1'b0;
        tick(1);
        // R9 collision: rise and write in same cycle
        wr_data = 32'h0013_2000;
        wr_en = 1'b1;
        cfg_flag = 1'b1;
        tick(1);
        wr_en = 1'b0;
        chk("R9 collision word", rd_data, 32'h0013_0000);
        cfg_flag = 1'b0;

        // R1 reset mid-run
        wr(32'h007F_C000);
        rst = 1'b1;
        tick(2);
        rst = 1'b0;
        chk("R1 after reset", rd_data, 32'h0000_2000);
        done();
    end
endmodule